// File: doc/BRIEF.md
# Pulse High/Low Time Measurement Sequencer

This block measures one cycle of a digital input waveform. After a start pulse it waits for the input to go high, then timestamps three transitions in turn against a free-running tick counter: the rising edge, the falling edge that ends the high phase, and the rising edge that ends the low phase. From these three stamps it reports how many ticks the signal spent high and how many it spent low. Their sum is the period.

The block arms itself for one edge polarity at a time. After each of the first two captures the 2-bit edge code is inverted, so rising becomes falling and falling becomes rising. After the third capture the block disarms and raises `done` for one cycle together with `valid`. A watchdog window, given in the same ticks as the timestamp counter and latched at start, ends a measurement that stalls because the input is flat or has no edges. In that case `done` pulses with `valid` low and both durations set to zero, so no stale numbers are reported.

A tick is one clock cycle. The input is registered once before edge detection. The edge code that is currently armed is visible on `armed_edge`.

Top module: `pulse_meter`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `done` and `valid` are 0, `high_ticks` and `low_ticks` are 0, and `armed_edge` is 2'b00. The edge codes are 2'b00 disarmed, 2'b01 rising, 2'b10 falling and 2'b11 either edge.
- R2: When `start` is sampled high while idle, `armed_edge` becomes 2'b01 on that clock edge. A level that is already high at start is not counted; the first capture is the first low-to-high transition seen after arming.
- R3: After the first and second captures the armed code is inverted by XOR with 2'b11, so the block waits for a falling edge during the high phase and for a rising edge after it.
- R4: On the third capture `done` pulses and `valid` is 1. `high_ticks` equals the number of clock cycles the input was high, and `low_ticks` the number of cycles it was low, between the three edges.
- R5: If the three captures are not complete when the armed cycle count reaches the latched timeout T, `done` pulses T+1 cycles after the start edge, with `valid`=0 and both durations 0. This applies whether no edge or some edges were seen.
- R6: `armed_edge` returns to 2'b00 on the same edge that raises `done`, for both a completed and a timed-out measurement.
- R7: `start` has no effect while a measurement is armed: neither the captures nor the timeout window restart.
- R8: `done` lasts exactly one cycle, and `valid`, `high_ticks` and `low_ticks` hold their values until the next `done`.
- R9: The durations are correct when the tick counter wraps between captures, provided each phase is shorter than 2^CNT_W ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one tick per cycle |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a measurement (ignored while armed) |
| timeout_ticks | input | CNT_W | Watchdog window in ticks, latched at start |
| sig_in | input | 1 | Signal under measurement |
| done | output | 1 | One-cycle end-of-measurement pulse |
| valid | output | 1 | All three edges were captured |
| high_ticks | output | CNT_W | High phase length in ticks |
| low_ticks | output | CNT_W | Low phase length in ticks |
| armed_edge | output | 2 | Edge code currently armed |

## Verification
The bench builds the block with CNT_W=8, so the tick counter wraps every 256 cycles. A measurement can then be placed deliberately across the wrap, and timeout windows from 0 up to almost the full counter range run within a short test. Pulse widths from one cycle to 120 cycles are used, together with timeouts of 0 and small windows. This reaches single-cycle phases, starting on a high level, partial captures that time out, and start pulses that land in the middle of a measurement.

// File: rtl/pm_pkg.sv
package pm_pkg;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_sel_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_ev_t;

    function automatic edge_sel_e flip_edge(edge_sel_e e);
        return edge_sel_e'(e ^ 2'b11);
    endfunction

    function automatic logic edge_hit(edge_sel_e sel, edge_ev_t ev);
        case (sel)
            EDGE_RISE: return ev.rise;
            EDGE_FALL: return ev.fall;
            EDGE_ANY:  return ev.rise | ev.fall;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pm_tick_counter.sv
module pm_tick_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] ticks
);
    always_ff @(posedge clk) begin
        if (rst) ticks <= '0;
        else     ticks <= ticks + 1'b1;
    end
endmodule

// File: rtl/pm_edge_watch.sv
module pm_edge_watch
    import pm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sig_in,
    output edge_ev_t ev
);
    logic sig_q, sig_qq;

    always_ff @(posedge clk) begin
        if (rst) begin
            sig_q  <= 1'b0;
            sig_qq <= 1'b0;
        end else begin
            sig_q  <= sig_in;
            sig_qq <= sig_q;
        end
    end

    always_comb begin
        ev.rise = sig_q & ~sig_qq;
        ev.fall = ~sig_q & sig_qq;
    end
endmodule

// File: rtl/pm_sequencer.sv
module pm_sequencer
    import pm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] timeout_ticks,
    input  logic [CNT_W-1:0] ticks,
    input  edge_ev_t         ev,
    output logic             done,
    output logic             valid,
    output logic [CNT_W-1:0] high_ticks,
    output logic [CNT_W-1:0] low_ticks,
    output edge_sel_e        armed_edge
);
    localparam int IDX_W = 2;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(2);

    seq_state_e       state;
    logic [IDX_W-1:0] idx;
    logic [CNT_W-1:0] stamp0, stamp1, elapsed, window;
    logic             hit, final_hit, expired;

    always_comb begin
        hit       = edge_hit(armed_edge, ev);
        final_hit = hit && (idx == LAST_IDX);
        expired   = (elapsed >= window);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            armed_edge <= EDGE_OFF;
            idx        <= '0;
            stamp0     <= '0;
            stamp1     <= '0;
            elapsed    <= '0;
            window     <= '0;
            done       <= 1'b0;
            valid      <= 1'b0;
            high_ticks <= '0;
            low_ticks  <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state      <= ST_ARMED;
                        armed_edge <= EDGE_RISE;
                        idx        <= '0;
                        elapsed    <= '0;
                        window     <= timeout_ticks;
                    end
                end
                default: begin
                    if (final_hit) begin
                        high_ticks <= stamp1 - stamp0;
                        low_ticks  <= ticks - stamp1;
                        valid      <= 1'b1;
                        done       <= 1'b1;
                        armed_edge <= EDGE_OFF;
                        state      <= ST_IDLE;
                    end else if (expired) begin
                        high_ticks <= '0;
                        low_ticks  <= '0;
                        valid      <= 1'b0;
                        done       <= 1'b1;
                        armed_edge <= EDGE_OFF;
                        state      <= ST_IDLE;
                    end else begin
                        elapsed <= elapsed + 1'b1;
                        if (hit) begin
                            if (idx == '0) stamp0 <= ticks;
                            else           stamp1 <= ticks;
                            idx        <= idx + 1'b1;
                            armed_edge <= flip_edge(armed_edge);
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/pulse_meter.sv
module pulse_meter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] timeout_ticks,
    input  logic             sig_in,
    output logic             done,
    output logic             valid,
    output logic [CNT_W-1:0] high_ticks,
    output logic [CNT_W-1:0] low_ticks,
    output logic [1:0]       armed_edge
);
    import pm_pkg::*;

    logic [CNT_W-1:0] ticks;
    edge_ev_t         ev;
    edge_sel_e        edge_q;

    pm_tick_counter #(.CNT_W(CNT_W)) u_ticks (
        .clk   (clk),
        .rst   (rst),
        .ticks (ticks)
    );

    pm_edge_watch u_edges (
        .clk    (clk),
        .rst    (rst),
        .sig_in (sig_in),
        .ev     (ev)
    );

    pm_sequencer #(.CNT_W(CNT_W)) u_seq (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .timeout_ticks (timeout_ticks),
        .ticks         (ticks),
        .ev            (ev),
        .done          (done),
        .valid         (valid),
        .high_ticks    (high_ticks),
        .low_ticks     (low_ticks),
        .armed_edge    (edge_q)
    );

    assign armed_edge = edge_q;
endmodule

// File: rtl/pm_checker.sv
module pm_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             done,
    input logic             valid,
    input logic [CNT_W-1:0] high_ticks,
    input logic [CNT_W-1:0] low_ticks,
    input logic [1:0]       armed_edge
);
    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    disarm_on_done_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (armed_edge == 2'b00));

    // R5
    zero_on_timeout_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !valid) |-> (high_ticks == '0 && low_ticks == '0));

    // R3
    edge_step_chk: assert property (@(posedge clk) disable iff (rst)
        (armed_edge != $past(armed_edge)) |->
            ((armed_edge == ($past(armed_edge) ^ 2'b11)) || (armed_edge == 2'b00) ||
             ($past(armed_edge) == 2'b00 && armed_edge == 2'b01)));

    // R2
    arm_rising_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(armed_edge) == 2'b00 && armed_edge != 2'b00) |->
            (armed_edge == 2'b01 && $past(start)));

    // R8
    hold_results_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(valid) && $stable(high_ticks) && $stable(low_ticks)));

    // R4
    valid_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(valid) |-> done);
endmodule

bind pulse_meter pm_checker #(.CNT_W(CNT_W)) u_pm_checker (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .done       (done),
    .valid      (valid),
    .high_ticks (high_ticks),
    .low_ticks  (low_ticks),
    .armed_edge (armed_edge)
);

// File: tb/test_pulse_meter.sv
module test_pulse_meter;
    localparam int CNT_W = 8;
    localparam int NVEC  = 6;
    localparam int VEC_H [NVEC] = '{1, 2, 5, 10, 37, 100};
    localparam int VEC_L [NVEC] = '{1, 5, 3, 20, 4, 100};

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [CNT_W-1:0] timeout_ticks = '0;
    logic             sig_in = 1'b0;
    logic             done, valid;
    logic [CNT_W-1:0] high_ticks, low_ticks;
    logic [1:0]       armed_edge;

    int  n_chk = 0;
    int  n_bad = 0;
    int  cyc = 0;
    bit  reported = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

    pulse_meter #(.CNT_W(CNT_W)) i_pulse_meter (
        .clk(clk), .rst(rst), .start(start), .timeout_ticks(timeout_ticks),
        .sig_in(sig_in), .done(done), .valid(valid),
        .high_ticks(high_ticks), .low_ticks(low_ticks), .armed_edge(armed_edge)
    );

    task automatic chk(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        end
        $finish;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    // waveform: init level at start, 3 low cycles, h high, l low, then high
    task automatic measure(int h, int l, logic init, bit poke_start);
        bit seen = 0;
        timeout_ticks = 8'd255;
        sig_in = init;
        pulse_start();
        chk("R2 armed rising", armed_edge, 1);
        sig_in = 1'b0;
        repeat (3) @(negedge clk);
        sig_in = 1'b1;
        for (int i = 0; i < h; i++) begin
            @(negedge clk);
            if (i == 1 && h >= 3) chk("R3 armed falling", armed_edge, 2);
            if (poke_start && i == 0) start = 1'b1;
            if (poke_start && i == 1) start = 1'b0;
        end
        sig_in = 1'b0;
        for (int i = 0; i < l; i++) begin
            @(negedge clk);
            if (i == 1 && l >= 3) chk("R3 armed rising again", armed_edge, 1);
        end
        sig_in = 1'b1;
        for (int i = 0; i < 20 && !seen; i++) begin
            @(negedge clk);
            if (done) seen = 1;
        end
        chk("R4 done seen", seen, 1);
        chk("R4 valid", valid, 1);
        chk("R4 high_ticks", high_ticks, h);
        chk("R4 low_ticks", low_ticks, l);
        chk("R6 disarmed at done", armed_edge, 0);
    endtask

    // returns number of posedges from the start edge until done is seen
    task automatic run_timeout(int t, int restart_at, output int n);
        timeout_ticks = CNT_W'(t);
        n = 0;
        @(negedge clk); start = 1'b1;
        for (int i = 0; i < 600; i++) begin
            @(posedge clk); #1;
            n++;
            start = (restart_at != 0 && n == restart_at);
            if (done) break;
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        report();
    end

    initial begin
        int n;
        bit seen;
        logic [CNT_W-1:0] h_keep, l_keep;

        repeat (3) @(negedge clk);
        chk("R1 done in reset", done, 0);
        chk("R1 valid in reset", valid, 0);
        chk("R1 high in reset", high_ticks, 0);
        chk("R1 armed in reset", armed_edge, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 low after reset", low_ticks, 0);
        chk("R1 armed after reset", armed_edge, 0);

        for (int v = 0; v < NVEC; v++) measure(VEC_H[v], VEC_L[v], 1'b0, 1'b0);

        // R8: results hold, done stays low
        h_keep = high_ticks; l_keep = low_ticks;
        repeat (5) @(negedge clk);
        chk("R8 done low after pulse", done, 0);
        chk("R8 high held", high_ticks, h_keep);
        chk("R8 low held", low_ticks, l_keep);
        chk("R8 valid held", valid, 1);

        // R2: input already high at start is not a capture
        measure(7, 9, 1'b1, 1'b0);

        // R7: start mid-measurement ignored
        measure(12, 6, 1'b0, 1'b1);

        // R9: place the measurement across a counter wrap
        while ((cyc % 256) != 200) @(negedge clk);
        measure(120, 120, 1'b0, 1'b0);

        // R5: flat input times out
        sig_in = 1'b0;
        run_timeout(5, 0, n);
        chk("R5 timeout latency T=5", n, 7);
        chk("R5 valid low", valid, 0);
        chk("R5 high zero", high_ticks, 0);
        chk("R5 low zero", low_ticks, 0);
        chk("R6 disarmed at timeout", armed_edge, 0);
        run_timeout(0, 0, n);
        chk("R5 timeout latency T=0", n, 2);

        // R7: restart attempt does not extend the window
        run_timeout(10, 4, n);
        chk("R7 window not restarted", n, 12);

        // R5: partial capture times out with zeros (no stale data)
        measure(3, 3, 1'b0, 1'b0);
        timeout_ticks = 8'd30;
        sig_in = 1'b0;
        pulse_start();
        repeat (2) @(negedge clk);
        sig_in = 1'b1;
        repeat (4) @(negedge clk);
        sig_in = 1'b0;
        seen = 0;
        for (int i = 0; i < 60 && !seen; i++) begin
            @(negedge clk);
            if (done) seen = 1;
        end
        chk("R5 partial done", seen, 1);
        chk("R5 partial valid", valid, 0);
        chk("R5 partial high", high_ticks, 0);
        chk("R5 partial low", low_ticks, 0);

        repeat (3) @(negedge clk);
        report();
    end
endmodule